// File: doc/BRIEF.md
# Bit-Serial Add/Subtract Unit with Sticky Overflow

This block is the arithmetic core of a small bit-serial processor. Two operand words, seven bits long by default, arrive one bit per clock with the least-significant bit first. A sequencer outside the block supplies a bit-time count that runs from 1 to 7. The full adder works on every clock. It returns each result bit in the same cycle as its operand bits. A carry register holds the carry between bit-times and passes it to the next bit.

The three arithmetic operations are add, subtract (two's complement) and decrement. They run only while the arithmetic-enable line is high. When that line is low, the adder's second input and its carry-in are held at zero. The result stream then copies the first operand, and no carry can occur.

One overflow flip-flop records the carry out of the final bit of an arithmetic word. It stays set until reset. The flag is visible on its own output. A skip-test output is also provided: it is high only when the flag is set and the sequencer asks for the skip-on-carry test.

Top module: `bit_serial_alu`

## Requirements
- R1: For an add (`op_sel` 2'b00, and also 2'b11), the `sum_bit` stream across bit-times 1..7 is the low seven bits of A+B, least-significant first. Each result bit appears combinationally in the same cycle as its operand bits.
- R2: Each word starts with a fresh carry-in at bit-time 1: 0 for add and decrement, 1 for subtract. A carry left over from the previous word has no effect. In bit-times 2..7 the carry-in is the carry out of the previous clock.
- R3: Subtract (`op_sel` 2'b01) produces A + ~B + 1, which is A−B mod 128. The final carry out is 1 exactly when A ≥ B.
- R4: Decrement (`op_sel` 2'b10) adds seven ones with carry-in 0, which gives A−1 mod 128. The final carry out is 1 exactly when A ≠ 0.
- R5: While `arith_en` is low, the second operand and the carry-in are forced to zero. `sum_bit` equals `opa_bit`, and the overflow flag does not change.
- R6: The overflow flag is set only on a clock where `bit_time` is 7, `arith_en` is high and the adder's carry out is 1. Carries out of bit-times 1..6 never set it.
- R7: Once set, the overflow flag stays set through later words, including words with no final carry, until reset.
- R8: A synchronous, active-high `rst` clears both the overflow flag and the carry register.
- R9: `skip_take` is high exactly when the overflow flag is set and `skip_test_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous clear, active high |
| bit_time | input | 3 | Current bit-time, 1..7; 0 when no word is in flight |
| arith_en | input | 1 | High during an arithmetic instruction |
| op_sel | input | 2 | 00 add, 01 subtract, 10 decrement, 11 add |
| opa_bit | input | 1 | Serial bit of the first operand |
| opb_bit | input | 1 | Serial bit of the second operand |
| skip_test_en | input | 1 | Sequencer request for the skip-on-carry test |
| sum_bit | output | 1 | Serial result bit |
| ovf_flag | output | 1 | Sticky overflow flag |
| skip_take | output | 1 | Skip condition: flag AND test request |

## Verification
A carry register that is not reloaded at bit-time 1 shows up in the first result bit of the next word. For example, an add of 1+1 that follows a word ending in a carry would give 3 instead of 2. A carry that does not propagate, or that leaks while the unit is idle, corrupts a result bit one cycle after the faulty bit-time. An overflow flip-flop that loads at the wrong bit-time, or that clears itself, is seen on `ovf_flag` and `skip_take` in the first idle cycle after the word ends. The bench therefore mixes words with early carries, words that reach the final carry, and words with no carry that follow a set flag.

// File: rtl/bit_serial_alu_pkg.sv
`timescale 1ns/1ps
package bit_serial_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DEC  = 2'b10,
    OP_ADD2 = 2'b11
  } alu_op_e;
endpackage

// File: rtl/bsa_operand_cond.sv
`timescale 1ns/1ps
// Conditions the second operand and picks the start-of-word carry.
module bsa_operand_cond
  import bit_serial_alu_pkg::*;
(
  input  logic       arith_en,
  input  logic [1:0] op_sel,
  input  logic       opb_bit,
  output logic       b_eff,
  output logic       cin_start
);
  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  always_comb begin
    b_eff     = 1'b0;
    cin_start = 1'b0;
    if (arith_en) begin
      unique case (op)
        OP_SUB:  begin b_eff = ~opb_bit; cin_start = 1'b1; end
        OP_DEC:  begin b_eff = 1'b1;     cin_start = 1'b0; end
        default: begin b_eff = opb_bit;  cin_start = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/bsa_carry_chain.sv
`timescale 1ns/1ps
// Full adder with the inter-bit carry register.
module bsa_carry_chain #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] bit_time,
  input  logic          arith_en,
  input  logic          a_bit,
  input  logic          b_eff,
  input  logic          cin_start,
  output logic          sum_bit,
  output logic          carry_out,
  output logic          carry_in
);
  localparam logic [TW-1:0] FIRST = TW'(1);

  logic carry_q;

  always_comb begin
    if (!arith_en)              carry_in = 1'b0;
    else if (bit_time == FIRST) carry_in = cin_start;
    else                        carry_in = carry_q;
  end

  assign sum_bit   = a_bit ^ b_eff ^ carry_in;
  assign carry_out = (a_bit & b_eff) | (carry_in & (a_bit ^ b_eff));

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= carry_out;
  end

  // R2: inside a word, the carry-in is the previous clock's carry out
  p_carry_link_r2: assert property (@(posedge clk) disable iff (rst)
    (arith_en && $past(arith_en) && bit_time > FIRST) |-> (carry_in == $past(carry_out)));
endmodule

// File: rtl/bsa_ovf_flag.sv
`timescale 1ns/1ps
// Sticky overflow flip-flop and the skip-on-carry test.
module bsa_ovf_flag #(
  parameter int TW    = 3,
  parameter int WBITS = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] bit_time,
  input  logic          arith_en,
  input  logic          carry_out,
  input  logic          skip_test_en,
  output logic          ovf_q,
  output logic          skip_take
);
  localparam logic [TW-1:0] LAST = TW'(WBITS);

  logic load_ovf;
  assign load_ovf = (bit_time == LAST) && arith_en && carry_out;

  always_ff @(posedge clk) begin
    if (rst)           ovf_q <= 1'b0;
    else if (load_ovf) ovf_q <= 1'b1;
  end

  assign skip_take = ovf_q & skip_test_en;

  // R6: the flag rises only after a final-bit carry of an arithmetic word
  p_ovf_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past((bit_time == LAST) && arith_en && carry_out));

  // R7: once set, the flag holds until reset
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/bit_serial_alu.sv
`timescale 1ns/1ps
module bit_serial_alu #(
  parameter int WBITS = 7,
  parameter int TW    = $clog2(WBITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] bit_time,
  input  logic          arith_en,
  input  logic [1:0]    op_sel,
  input  logic          opa_bit,
  input  logic          opb_bit,
  input  logic          skip_test_en,
  output logic          sum_bit,
  output logic          ovf_flag,
  output logic          skip_take
);
  logic b_eff, cin_start, carry_out, carry_in;

  bsa_operand_cond u_cond (
    .arith_en  (arith_en),
    .op_sel    (op_sel),
    .opb_bit   (opb_bit),
    .b_eff     (b_eff),
    .cin_start (cin_start)
  );

  bsa_carry_chain #(.TW(TW)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .bit_time  (bit_time),
    .arith_en  (arith_en),
    .a_bit     (opa_bit),
    .b_eff     (b_eff),
    .cin_start (cin_start),
    .sum_bit   (sum_bit),
    .carry_out (carry_out),
    .carry_in  (carry_in)
  );

  bsa_ovf_flag #(.TW(TW), .WBITS(WBITS)) u_ovf (
    .clk          (clk),
    .rst          (rst),
    .bit_time     (bit_time),
    .arith_en     (arith_en),
    .carry_out    (carry_out),
    .skip_test_en (skip_test_en),
    .ovf_q        (ovf_flag),
    .skip_take    (skip_take)
  );

  // R5: when idle, the result copies the first operand and no carry forms
  p_idle_pass_r5: assert property (@(posedge clk) disable iff (rst)
    !arith_en |-> (sum_bit == opa_bit && !carry_out && !carry_in));
endmodule

// File: tb/test_bit_serial_alu.sv
`timescale 1ns/1ps
module test_bit_serial_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bit_time = 3'd0;
  logic       arith_en = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic       opa_bit = 1'b0, opb_bit = 1'b0, skip_test_en = 1'b0;
  logic       sum_bit, ovf_flag, skip_take;

  always #10 clk = ~clk;  // 50 MHz

  bit_serial_alu i_bit_serial_alu (
    .clk(clk), .rst(rst), .bit_time(bit_time), .arith_en(arith_en),
    .op_sel(op_sel), .opa_bit(opa_bit), .opb_bit(opb_bit),
    .skip_test_en(skip_test_en), .sum_bit(sum_bit), .ovf_flag(ovf_flag),
    .skip_take(skip_take)
  );

  typedef struct { logic exp_bit; string tag; int pos; } exp_item_t;
  exp_item_t exp_q[$];
  int  n_checks = 0, n_fail = 0;
  logic ovf_model = 1'b0;
  bit  done = 1'b0;

  // Monitor: pops expected result bits as the design produces them
  initial begin
    forever begin
      @(negedge clk); #5;
      if (exp_q.size() > 0) begin
        exp_item_t it;
        it = exp_q.pop_front();
        n_checks++;
        if (sum_bit !== it.exp_bit) begin
          n_fail++;
          $display("FAIL %s sum_bit pos %0d actual %b expected %b", it.tag, it.pos, sum_bit, it.exp_bit);
        end
      end
    end
  end

  // Driver: presents one word and queues its expected result bits
  task automatic run_word(input logic [1:0] op, input logic [6:0] a, input logic [6:0] b,
                          input logic act, input string tag);
    logic [7:0] total;
    logic [6:0] beff;
    logic       cin;
    beff = 7'd0; cin = 1'b0;
    if (act) begin
      case (op)
        2'b01:   begin beff = ~b;    cin = 1'b1; end
        2'b10:   begin beff = 7'h7F; cin = 1'b0; end
        default: begin beff = b;     cin = 1'b0; end
      endcase
    end
    total = {1'b0, a} + {1'b0, beff} + {7'd0, cin};
    for (int t = 1; t <= 7; t++) begin
      exp_item_t it;
      @(negedge clk);
      bit_time = 3'(t); arith_en = act; op_sel = op;
      opa_bit = a[t-1]; opb_bit = b[t-1];
      it.exp_bit = total[t-1]; it.tag = tag; it.pos = t;
      exp_q.push_back(it);
    end
    if (act && total[7]) ovf_model = 1'b1;
    @(negedge clk);
    bit_time = 3'd0; arith_en = 1'b0; opa_bit = 1'b0; opb_bit = 1'b0;
  endtask

  task automatic check_flags(input logic en, input string tag);
    @(negedge clk);
    skip_test_en = en;
    #5;
    n_checks++;
    if (ovf_flag !== ovf_model) begin
      n_fail++;
      $display("FAIL %s ovf_flag actual %b expected %b", tag, ovf_flag, ovf_model);
    end
    n_checks++;
    if (skip_take !== (ovf_model & en)) begin
      n_fail++;
      $display("FAIL R9 (%s) skip_take actual %b expected %b", tag, skip_take, ovf_model & en);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ovf_model = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_flags(1'b1, "R8 reset state");
    run_word(2'b00, 7'd3, 7'd4, 1'b1, "R1 add small");
    check_flags(1'b1, "R6 no final carry");
    run_word(2'b00, 7'h3F, 7'h01, 1'b1, "R6 inner carries");
    check_flags(1'b1, "R6 inner carries no flag");
    run_word(2'b00, 7'h7F, 7'h7F, 1'b0, "R5 idle passthrough");
    check_flags(1'b1, "R5 idle leaves flag");
    run_word(2'b11, 7'h40, 7'h40, 1'b1, "R1 add alt code final carry");
    check_flags(1'b0, "R9 flag set test off");
    check_flags(1'b1, "R6 flag set test on");
    run_word(2'b00, 7'd1, 7'd1, 1'b1, "R2 carry reload at T1");
    check_flags(1'b1, "R7 sticky");
    do_reset();
    check_flags(1'b1, "R8 reset clears");
    run_word(2'b01, 7'd5, 7'd3, 1'b1, "R3 sub no borrow");
    check_flags(1'b1, "R3 sub carry sets flag");
    do_reset();
    run_word(2'b01, 7'd3, 7'd5, 1'b1, "R3 sub borrow");
    check_flags(1'b1, "R3 sub borrow no flag");
    run_word(2'b10, 7'd0, 7'h55, 1'b1, "R4 dec zero");
    check_flags(1'b1, "R4 dec zero no flag");
    run_word(2'b10, 7'd10, 7'h2A, 1'b1, "R4 dec ten");
    check_flags(1'b1, "R4 dec carry sets flag");
    run_word(2'b01, 7'h2C, 7'h13, 1'b1, "R2 sub after carry");
    run_word(2'b00, 7'h55, 7'h2A, 1'b1, "R1 add alternating");
    check_flags(1'b0, "R7 still set");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule